// File: doc/BRIEF.md
# Delayed Conditional Branch Sequencer

This block holds the fetch address of a processor whose instructions are all two bytes wide, and handles conditional relative branches that carry one delay slot. Each cycle the decoder may issue the instruction sitting at the current fetch address. If that instruction is a branch, it also supplies a 4-bit condition selector and an 8-bit signed halfword displacement. The sequencer reads the N, Z, V and C flags in that same cycle, decides whether the branch is taken, and records the target. It then lets exactly one more instruction issue: the delay slot, which runs whether or not the branch is taken. Only once that slot instruction has issued does it move the fetch address to the target, or let it fall through.

The issue interface is a plain valid strobe with no back-pressure. The sequencer accepts one instruction in every cycle in which `issue_valid` is high. A stall is expressed by holding `issue_valid` low, which freezes the fetch address and any pending branch decision. `delay_slot` tells the pipeline that the instruction now at the fetch address is a delay slot. `branch_taken` tells it whether a redirect will follow that slot. A branch presented inside a delay slot is not executed, and `slot_err` is raised for it.

Top module: `brseq_top`

## Requirements
- R1: After reset, `fetch_pc` equals the reset vector with bit 0 cleared, and `delay_slot`, `branch_taken` and `slot_err` are low.
- R2: When a non-branch instruction issues outside a delay slot, `fetch_pc` advances by 2 on the next cycle. In a cycle without `issue_valid`, `fetch_pc` and the pending branch state stay unchanged.
- R3: The branch decision follows the condition selector. Selector 0 is always taken and selector 1 is never taken. Selectors 2 and 3 are taken on Z=1 and Z=0, 4 and 5 on C=1 and C=0, 6 and 7 on N=1 and N=0, and 8 and 9 on V=1 and V=0. Selectors 10 and 11 are taken when N XOR V is 1 and when it is 0. Selectors 12 and 13 are taken when (N XOR V) OR Z is 1 and when it is 0. Selectors 14 and 15 are taken when C OR Z is 1 and when it is 0.
- R4: A taken branch at address P with displacement d (two's complement) redirects `fetch_pc` to P + 2 + 2·d, computed modulo 2^32.
- R5: In the cycle after a branch issues, `fetch_pc` is P + 2 and `delay_slot` is high. The redirect does not happen until the slot instruction has issued.
- R6: When a branch is not taken, the instruction after the delay slot is fetched from the slot address + 2.
- R7: The flags are sampled only in the cycle the branch issues. Flag values presented while the delay slot issues do not change the decision.
- R8: A branch issued while `delay_slot` is high raises `slot_err` in that cycle. It does not change the pending decision or the target, and it opens no new delay slot.
- R9: `branch_taken` is high exactly while `delay_slot` is high and the pending branch was taken.
- R10: Bit 0 of `fetch_pc` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | The instruction at `fetch_pc` issues this cycle |
| issue_is_branch | input | 1 | The issuing instruction is a conditional relative branch |
| issue_cc | input | 4 | Condition selector of the branch |
| issue_disp | input | 8 | Signed displacement in halfwords |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| fetch_pc | output | 32 | Address of the next instruction to issue |
| delay_slot | output | 1 | The instruction at `fetch_pc` is a delay slot |
| branch_taken | output | 1 | The pending branch will redirect after the slot |
| slot_err | output | 1 | A branch is issuing inside a delay slot (combinational) |

## Verification
The bench runs every condition selector against all sixteen flag patterns. A design with a swapped or inverted decode, such as selector 1 treated as taken or the signed and unsigned compare pairs exchanged, would redirect on the wrong pattern. It changes the flags while the slot issues, which catches a design that re-evaluates late. It also holds `issue_valid` low inside the slot, which catches a design that redirects on a timer instead of on the slot instruction issuing. It drives displacements of -128, +127 and zero, and uses a reset vector near the top of the address space, so that a design that forgets sign extension, the doubling or the wrap-around lands at a wrong address. Branches placed inside the slot show whether a design wrongly replaces the pending target or opens a second slot.

// File: rtl/brseq_pkg.sv
package brseq_pkg;
  localparam int CC_W = 4;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  // Index of the base test; the low selector bit inverts it.
  typedef enum logic [2:0] {
    BASE_ALWAYS = 3'd0,
    BASE_Z      = 3'd1,
    BASE_C      = 3'd2,
    BASE_N      = 3'd3,
    BASE_V      = 3'd4,
    BASE_LT     = 3'd5,
    BASE_LE     = 3'd6,
    BASE_LS     = 3'd7
  } base_e;
endpackage

// File: rtl/brseq_cond_eval.sv
module brseq_cond_eval
  import brseq_pkg::*;
(
  input  flags_t                flg,
  input  logic [CC_W-1:0]       cc,
  output logic                  cond_ok
);
  localparam int NBASE = 1 << (CC_W - 1);

  logic [NBASE-1:0] base;
  logic             sgn_lt;

  always_comb begin
    sgn_lt            = flg.n ^ flg.v;
    base              = '0;
    base[BASE_ALWAYS] = 1'b1;
    base[BASE_Z]      = flg.z;
    base[BASE_C]      = flg.c;
    base[BASE_N]      = flg.n;
    base[BASE_V]      = flg.v;
    base[BASE_LT]     = sgn_lt;
    base[BASE_LE]     = sgn_lt | flg.z;
    base[BASE_LS]     = flg.c | flg.z;
  end

  // Odd selectors are the negation of their even partner.
  assign cond_ok = base[cc[CC_W-1:1]] ^ cc[0];
endmodule

// File: rtl/brseq_target_calc.sv
module brseq_target_calc #(
  parameter int PC_W   = 32,
  parameter int DISP_W = 8
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  output logic [PC_W-1:0]   seq_pc,
  output logic [PC_W-1:0]   tgt_pc
);
  localparam int OFF_W  = DISP_W + 1;
  localparam int EXT_W  = PC_W - OFF_W;

  logic [PC_W-1:0] byte_off;

  assign byte_off = {{EXT_W{disp[DISP_W-1]}}, disp, 1'b0};
  assign seq_pc   = pc + PC_W'(2);
  assign tgt_pc   = seq_pc + byte_off;
endmodule

// File: rtl/brseq_pc_ctrl.sv
module brseq_pc_ctrl #(
  parameter int              PC_W      = 32,
  parameter logic [PC_W-1:0] RESET_VEC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  input  logic            is_branch,
  input  logic            cond_ok,
  input  logic [PC_W-1:0] seq_pc,
  input  logic [PC_W-1:0] tgt_pc,
  output logic [PC_W-1:0] pc,
  output logic            in_slot,
  output logic            take_pend,
  output logic            bad_branch
);
  localparam logic [PC_W-1:0] RST_PC = {RESET_VEC[PC_W-1:1], 1'b0};

  logic [PC_W-1:0] pc_q, pc_n;
  logic [PC_W-1:0] tgt_q, tgt_n;
  logic            slot_q, slot_n;
  logic            take_q, take_n;

  always_comb begin
    pc_n   = pc_q;
    tgt_n  = tgt_q;
    slot_n = slot_q;
    take_n = take_q;
    if (issue_valid) begin
      if (slot_q) begin
        // The slot instruction issues: resolve the pending branch.
        pc_n   = take_q ? tgt_q : seq_pc;
        slot_n = 1'b0;
        take_n = 1'b0;
      end else if (is_branch) begin
        pc_n   = seq_pc;
        tgt_n  = tgt_pc;
        slot_n = 1'b1;
        take_n = cond_ok;
      end else begin
        pc_n   = seq_pc;
      end
    end
    pc_n[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= RST_PC;
      tgt_q  <= '0;
      slot_q <= 1'b0;
      take_q <= 1'b0;
    end else begin
      pc_q   <= pc_n;
      tgt_q  <= tgt_n;
      slot_q <= slot_n;
      take_q <= take_n;
    end
  end

  assign pc         = pc_q;
  assign in_slot    = slot_q;
  assign take_pend  = slot_q & take_q;
  assign bad_branch = issue_valid & is_branch & slot_q;
endmodule

// File: rtl/brseq_top.sv
module brseq_top
  import brseq_pkg::*;
#(
  parameter int                PC_W      = 32,
  parameter int                DISP_W    = 8,
  parameter logic [PC_W-1:0]   RESET_VEC = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic              issue_is_branch,
  input  logic [CC_W-1:0]   issue_cc,
  input  logic [DISP_W-1:0] issue_disp,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_v,
  input  logic              flag_c,
  output logic [PC_W-1:0]   fetch_pc,
  output logic              delay_slot,
  output logic              branch_taken,
  output logic              slot_err
);
  flags_t          flg;
  logic            cond_ok;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] tgt_pc;

  assign flg = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};

  brseq_cond_eval u_cond (
    .flg     (flg),
    .cc      (issue_cc),
    .cond_ok (cond_ok)
  );

  brseq_target_calc #(
    .PC_W   (PC_W),
    .DISP_W (DISP_W)
  ) u_tgt (
    .pc     (fetch_pc),
    .disp   (issue_disp),
    .seq_pc (seq_pc),
    .tgt_pc (tgt_pc)
  );

  brseq_pc_ctrl #(
    .PC_W      (PC_W),
    .RESET_VEC (RESET_VEC)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .is_branch   (issue_is_branch),
    .cond_ok     (cond_ok),
    .seq_pc      (seq_pc),
    .tgt_pc      (tgt_pc),
    .pc          (fetch_pc),
    .in_slot     (delay_slot),
    .take_pend   (branch_taken),
    .bad_branch  (slot_err)
  );
endmodule

// File: rtl/brseq_checks.sv
module brseq_checks #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue_valid,
  input logic            issue_is_branch,
  input logic [PC_W-1:0] fetch_pc,
  input logic            delay_slot,
  input logic            branch_taken,
  input logic            slot_err
);
  // R2: plain instruction steps by one halfword
  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !delay_slot && !issue_is_branch) |=>
      (fetch_pc == $past(fetch_pc) + PC_W'(2)));

  // R2: no issue, no movement
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_valid) |=> ($stable(fetch_pc) && $stable(delay_slot) && $stable(branch_taken)));

  // R5: branch opens the slot at the next halfword
  assert_slot_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !delay_slot && issue_is_branch) |=>
      (delay_slot && fetch_pc == $past(fetch_pc) + PC_W'(2)));

  // R6: untaken branch falls through after the slot
  assert_fallthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && delay_slot && !branch_taken) |=>
      (!delay_slot && fetch_pc == $past(fetch_pc) + PC_W'(2)));

  // R8: error only inside a slot, and the slot closes afterwards
  assert_err_in_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_err |-> delay_slot);
  assert_err_no_reopen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_err |=> !delay_slot);

  // R9: taken indication only while a slot is pending
  assert_taken_in_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    branch_taken |-> delay_slot);

  // R10: halfword alignment
  assert_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_pc[0] == 1'b0);
endmodule

bind brseq_top brseq_checks #(.PC_W(PC_W)) u_brseq_checks (
  .clk             (clk),
  .rst_n           (rst_n),
  .issue_valid     (issue_valid),
  .issue_is_branch (issue_is_branch),
  .fetch_pc        (fetch_pc),
  .delay_slot      (delay_slot),
  .branch_taken    (branch_taken),
  .slot_err        (slot_err)
);

// File: tb/brseq_top_bench.sv
`timescale 1ns/1ps
module brseq_top_bench;
  localparam logic [31:0] RVEC = 32'hFFFF_FF80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic        issue_is_branch = 1'b0;
  logic [3:0]  issue_cc = '0;
  logic [7:0]  issue_disp = '0;
  logic        flag_n = 1'b0, flag_z = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
  logic [31:0] fetch_pc;
  logic        delay_slot, branch_taken, slot_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  logic [31:0] m_pc;
  logic [31:0] m_tgt;
  bit          m_slot;
  bit          m_take;
  string       pc_tag;

  always #2 clk = ~clk;

  brseq_top #(.RESET_VEC(RVEC)) u_brseq_top (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .issue_is_branch(issue_is_branch),
    .issue_cc(issue_cc), .issue_disp(issue_disp),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .fetch_pc(fetch_pc), .delay_slot(delay_slot),
    .branch_taken(branch_taken), .slot_err(slot_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit ref_cond(input logic [3:0] cc, input bit n, z, v, c);
    case (cc)
      4'd0:  return 1'b1;
      4'd1:  return 1'b0;
      4'd2:  return z;
      4'd3:  return !z;
      4'd4:  return c;
      4'd5:  return !c;
      4'd6:  return n;
      4'd7:  return !n;
      4'd8:  return v;
      4'd9:  return !v;
      4'd10: return n != v;
      4'd11: return n == v;
      4'd12: return (n != v) || z;
      4'd13: return !((n != v) || z);
      4'd14: return c || z;
      default: return !(c || z);
    endcase
  endfunction

  task automatic check_regs();
    check(pc_tag, fetch_pc, m_pc);
    check("R10", {31'd0, fetch_pc[0]}, 32'd0);
    check("R5", {31'd0, delay_slot}, {31'd0, m_slot});
    check("R3 R9", {31'd0, branch_taken}, {31'd0, m_slot && m_take});
  endtask

  // One cycle: drive at the falling edge, check the combinational error,
  // advance the reference model, then check registered outputs.
  task automatic step(input bit v, input bit br, input logic [3:0] cc,
                      input logic [7:0] d, input logic [3:0] f);
    bit exp_err;
    int off;
    issue_valid = v; issue_is_branch = br; issue_cc = cc; issue_disp = d;
    {flag_n, flag_z, flag_v, flag_c} = f;
    #1;
    exp_err = v && br && m_slot;
    check("R8", {31'd0, slot_err}, {31'd0, exp_err});
    if (v) begin
      if (m_slot) begin
        pc_tag = m_take ? "R4 R7" : "R6 R7";
        m_pc   = m_take ? m_tgt : m_pc + 32'd2;
        m_slot = 1'b0;
        m_take = 1'b0;
      end else if (br) begin
        off    = int'($signed(d));
        m_tgt  = m_pc + 32'd2 + 32'(off * 2);
        m_take = ref_cond(cc, f[3], f[2], f[1], f[0]);
        m_slot = 1'b1;
        m_pc   = m_pc + 32'd2;
        pc_tag = "R5";
      end else begin
        m_pc   = m_pc + 32'd2;
        pc_tag = "R2";
      end
    end else begin
      pc_tag = "R2";
    end
    @(posedge clk);
    @(negedge clk);
    check_regs();
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_pc = {RVEC[31:1], 1'b0};
    m_slot = 1'b0; m_take = 1'b0; m_tgt = '0;
    pc_tag = "R1";
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", fetch_pc, m_pc);
    check("R1", {29'd0, delay_slot, branch_taken, slot_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_regs();

    // every selector against every flag pattern; slot flags flipped (R3, R7)
    for (int cc = 0; cc < 16; cc++) begin
      for (int f = 0; f < 16; f++) begin
        step(1, 1, 4'(cc), 8'(f * 17 - 100), 4'(f));
        step(1, 0, 4'd0, 8'd0, ~4'(f));
        step(1, 0, 4'd0, 8'd0, 4'(f));
      end
    end

    // displacement extremes, wrap past the top of the address space (R4)
    step(1, 1, 4'd0, 8'h7F, 4'd0);  step(1, 0, 4'd0, 8'd0, 4'd0);
    step(1, 1, 4'd0, 8'h80, 4'd0);  step(1, 0, 4'd0, 8'd0, 4'd0);
    step(1, 1, 4'd0, 8'h00, 4'd0);  step(1, 0, 4'd0, 8'd0, 4'd0);

    // stall inside the slot: no early redirect (R2, R5)
    step(1, 1, 4'd2, 8'h10, 4'b0100);
    step(0, 0, 4'd0, 8'd0, 4'd0);
    step(0, 1, 4'd0, 8'h33, 4'd0);
    step(1, 0, 4'd0, 8'd0, 4'd0);

    // branch inside the slot is rejected (R8)
    step(1, 1, 4'd1, 8'h20, 4'd0);
    step(1, 1, 4'd0, 8'h40, 4'd0);
    step(1, 0, 4'd0, 8'd0, 4'd0);
    step(1, 1, 4'd0, 8'hF0, 4'd0);
    step(1, 1, 4'd1, 8'h05, 4'd0);
    step(1, 0, 4'd0, 8'd0, 4'd0);

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) != 0, ($urandom % 3) == 0, 4'($urandom),
           8'($urandom), 4'($urandom));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule